// File: doc/BRIEF.md
# Cache Miss Type Classifier

This block sits beside a set-associative L1 data cache and watches its access stream. Each access that really misses in the cache is labelled as one of three kinds. A compulsory miss is on a line never referenced since reset. A capacity miss is on a line that is known but would also miss in a fully associative LRU cache of the same number of lines. A conflict miss is any other miss: it would have hit in that fully associative cache, so it comes from set mapping. Accesses that hit in the cache are not labelled. Half-misses are also not labelled: these are accesses to a line that an outstanding miss is already fetching.

Two models run next to the real cache. A bitmap over the line address space records every line referenced since reset, and stands in for an infinite cache. A shadow tag store of `SHADOW_LINES` entries keeps lines in recency order. Both are consulted as they stood before the current access, and both are then updated by every access that is not a half-miss, whether it hit or missed. The cache side presents line addresses, since the 64-byte offset bits are removed before the block. The block counts each miss class in its own counter, and it also counts read misses and write misses separately.

Accesses enter on a valid/ready pair and are accepted on a cycle where both are high. Ready is low while reset is asserted and for the one cycle after reset is released. After that it stays high, so the block never applies back-pressure in normal operation and takes one access per cycle.

Top module: `miss_classifier`

## Requirements
- R1: `acc_ready` is 0 during reset and in the first cycle after reset is released, then 1. An access is accepted only on a cycle with `acc_valid` and `acc_ready` both high, and a cycle with `acc_valid` low changes neither the counters nor the model state.
- R2: An accepted access with `acc_hit`=0 and `acc_half`=0 is a miss. A miss on a line not referenced since reset increments `comp_cnt` by one.
- R3: A miss on a line referenced before, but not among the `SHADOW_LINES` most recently referenced distinct lines, increments `cap_cnt` by one.
- R4: A miss on a line that is among the `SHADOW_LINES` most recently referenced distinct lines increments `conf_cnt` by one.
- R5: An accepted access with `acc_half`=1 changes no counter and does not mark its line as referenced, so a later miss on that line is still compulsory.
- R6: An accepted access with `acc_hit`=1 and `acc_half`=0 changes no counter, but it marks its line as referenced and makes it most recent.
- R7: Each miss increments `wr_miss_cnt` when `acc_write`=1 and `rd_miss_cnt` when `acc_write`=0. While no counter is saturated, comp+cap+conf equals rd+wr.
- R8: Recency is LRU. A reference to a line already in the shadow makes it the most recent line, and a new line evicts the least recent one.
- R9: Every counter saturates at its all-ones value.
- R10: Synchronous reset clears all counters, the referenced-line record and the shadow store.
- R11: A counter reflects an access in the cycle after the one in which the access is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access present |
| acc_ready | output | 1 | Block can accept an access |
| acc_line | input | LINE_W | Line address of the access |
| acc_hit | input | 1 | Access hit in the real cache |
| acc_half | input | 1 | Access is a half-miss |
| acc_write | input | 1 | 1 = write, 0 = read |
| comp_cnt | output | CNT_W | Compulsory miss count |
| cap_cnt | output | CNT_W | Capacity miss count |
| conf_cnt | output | CNT_W | Conflict miss count |
| rd_miss_cnt | output | CNT_W | Read miss count |
| wr_miss_cnt | output | CNT_W | Write miss count |

## Verification
The first pattern is a run of fresh lines. It separates compulsory misses from the rest and fills the shadow store. Repeat misses are then placed just inside and just outside the recency window, which shows conflict and capacity apart. In one pattern a real-cache hit refreshes an old line before a new line arrives, so only the LRU victim turns into a capacity miss. Half-misses, real-cache hits and idle cycles on new lines are each followed by a miss on the same line, and that miss shows whether the earlier access touched the models. A second instance with 3-bit counters shows saturation, and a reset in the middle of the run shows that previously seen lines become compulsory again.

// File: rtl/miss_cls_pkg.sv
package miss_cls_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_COMP = 2'd1,
    CLS_CAP  = 2'd2,
    CLS_CONF = 2'd3
  } miss_cls_e;

  localparam int NUM_CNT = 5;
  localparam int IDX_COMP = 0;
  localparam int IDX_CAP  = 1;
  localparam int IDX_CONF = 2;
  localparam int IDX_RD   = 3;
  localparam int IDX_WR   = 4;
endpackage

// File: rtl/seen_bitmap.sv
module seen_bitmap #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mark,
  input  logic [IDX_W-1:0] idx,
  output logic             seen
);
  localparam int NBITS = 1 << IDX_W;

  logic [NBITS-1:0] bits_q;

  // value before this access updates it
  assign seen = bits_q[idx];

  always_ff @(posedge clk) begin
    if (rst) bits_q <= '0;
    else if (mark) bits_q[idx] <= 1'b1;
  end

  // R6
  seen_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    mark |=> bits_q[$past(idx)]);
endmodule

// File: rtl/fa_lru_shadow.sv
module fa_lru_shadow #(
  parameter int TAG_W = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [TAG_W-1:0] tag,
  output logic             hit
);
  localparam int POS_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // slot 0 is most recent, slot DEPTH-1 least recent
  logic [TAG_W-1:0] tags_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] match;
  logic [POS_W-1:0] pos;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) match[i] = vld_q[i] && (tags_q[i] == tag);
  end

  assign hit = |match;

  // hit slot, or the last slot on a miss: slots up to pos shift down
  always_comb begin
    pos = POS_W'(DEPTH - 1);
    for (int i = DEPTH - 1; i >= 0; i--) if (match[i]) pos = POS_W'(i);
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) begin
            vld_q[0]  <= 1'b0;
            tags_q[0] <= '0;
          end else if (touch) begin
            vld_q[0]  <= 1'b1;
            tags_q[0] <= tag;
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) begin
            vld_q[g]  <= 1'b0;
            tags_q[g] <= '0;
          end else if (touch && (POS_W'(g) <= pos)) begin
            vld_q[g]  <= vld_q[g-1];
            tags_q[g] <= tags_q[g-1];
          end
        end
      end
    end
  endgenerate

  // R8
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
  // R8
  mru_insert_chk: assert property (@(posedge clk) disable iff (rst)
    touch |=> (vld_q[0] && tags_q[0] == $past(tag)));
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (inc && q != MAXV) q <= q + 1'b1;
  end

  // R11
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && q != MAXV) |=> q == $past(q) + 1'b1);
  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (q == MAXV) |=> q == MAXV);
endmodule

// File: rtl/miss_classifier.sv
module miss_classifier #(
  parameter int LINE_W       = 8,
  parameter int SHADOW_LINES = 8,
  parameter int CNT_W        = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [LINE_W-1:0] acc_line,
  input  logic              acc_hit,
  input  logic              acc_half,
  input  logic              acc_write,
  output logic [CNT_W-1:0]  comp_cnt,
  output logic [CNT_W-1:0]  cap_cnt,
  output logic [CNT_W-1:0]  conf_cnt,
  output logic [CNT_W-1:0]  rd_miss_cnt,
  output logic [CNT_W-1:0]  wr_miss_cnt
);
  import miss_cls_pkg::*;

  localparam int SUM_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic ready_q;
  logic take, touch, miss;
  logic seen, sh_hit;
  miss_cls_e cls;
  logic [NUM_CNT-1:0] inc;
  logic [CNT_W-1:0] cnt [NUM_CNT];

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else ready_q <= 1'b1;
  end
  assign acc_ready = ready_q;

  assign take  = acc_valid && ready_q;
  assign touch = take && !acc_half;
  assign miss  = touch && !acc_hit;

  seen_bitmap #(.IDX_W(LINE_W)) u_seen (
    .clk(clk), .rst(rst), .mark(touch), .idx(acc_line), .seen(seen)
  );

  fa_lru_shadow #(.TAG_W(LINE_W), .DEPTH(SHADOW_LINES)) u_shadow (
    .clk(clk), .rst(rst), .touch(touch), .tag(acc_line), .hit(sh_hit)
  );

  always_comb begin
    if (!miss)       cls = CLS_NONE;
    else if (!seen)  cls = CLS_COMP;
    else if (!sh_hit) cls = CLS_CAP;
    else             cls = CLS_CONF;
  end

  always_comb begin
    inc           = '0;
    inc[IDX_COMP] = (cls == CLS_COMP);
    inc[IDX_CAP]  = (cls == CLS_CAP);
    inc[IDX_CONF] = (cls == CLS_CONF);
    inc[IDX_RD]   = miss && !acc_write;
    inc[IDX_WR]   = miss && acc_write;
  end

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      sat_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .inc(inc[g]), .q(cnt[g])
      );
    end
  endgenerate

  assign comp_cnt    = cnt[IDX_COMP];
  assign cap_cnt     = cnt[IDX_CAP];
  assign conf_cnt    = cnt[IDX_CONF];
  assign rd_miss_cnt = cnt[IDX_RD];
  assign wr_miss_cnt = cnt[IDX_WR];

  // R1
  ready_low_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !acc_ready);
  // R5
  half_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (take && acc_half) |=> ($stable(comp_cnt) && $stable(cap_cnt) &&
      $stable(conf_cnt) && $stable(rd_miss_cnt) && $stable(wr_miss_cnt)));
  // R7
  miss_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (comp_cnt != CMAX && cap_cnt != CMAX && conf_cnt != CMAX &&
     rd_miss_cnt != CMAX && wr_miss_cnt != CMAX) |->
    (SUM_W'(comp_cnt) + SUM_W'(cap_cnt) + SUM_W'(conf_cnt) ==
     SUM_W'(rd_miss_cnt) + SUM_W'(wr_miss_cnt)));
endmodule

// File: tb/miss_classifier_bench.sv
module miss_classifier_bench;
  localparam int LW = 8;
  localparam int SL = 8;
  localparam int CW = 32;
  localparam int SW = 3;

  typedef struct {
    int    due;
    int    e[5];
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0;
  logic [LW-1:0] acc_line = '0;
  logic acc_hit = 1'b0, acc_half = 1'b0, acc_write = 1'b0;
  logic acc_ready, s_ready;
  logic [CW-1:0] c_comp, c_cap, c_conf, c_rd, c_wr;
  logic [SW-1:0] s_comp, s_cap, s_conf, s_rd, s_wr;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int e[5] = '{0, 0, 0, 0, 0};
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  miss_classifier #(.LINE_W(LW), .SHADOW_LINES(SL), .CNT_W(CW)) u_miss_classifier (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_line(acc_line), .acc_hit(acc_hit), .acc_half(acc_half), .acc_write(acc_write),
    .comp_cnt(c_comp), .cap_cnt(c_cap), .conf_cnt(c_conf),
    .rd_miss_cnt(c_rd), .wr_miss_cnt(c_wr)
  );

  miss_classifier #(.LINE_W(LW), .SHADOW_LINES(SL), .CNT_W(SW)) u_sat (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ready(s_ready),
    .acc_line(acc_line), .acc_hit(acc_hit), .acc_half(acc_half), .acc_write(acc_write),
    .comp_cnt(s_comp), .cap_cnt(s_cap), .conf_cnt(s_conf),
    .rd_miss_cnt(s_rd), .wr_miss_cnt(s_wr)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops each expected snapshot one cycle after its access (R11)
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due <= cyc) begin
      exp_t it;
      it = q.pop_front();
      chk(c_comp == CW'(it.e[0]), it.tag, "comp_cnt", c_comp, it.e[0]);
      chk(c_cap  == CW'(it.e[1]), it.tag, "cap_cnt",  c_cap,  it.e[1]);
      chk(c_conf == CW'(it.e[2]), it.tag, "conf_cnt", c_conf, it.e[2]);
      chk(c_rd   == CW'(it.e[3]), it.tag, "rd_miss_cnt", c_rd, it.e[3]);
      chk(c_wr   == CW'(it.e[4]), it.tag, "wr_miss_cnt", c_wr, it.e[4]);
    end
  end

  // driver: cls 0 none, 1 compulsory, 2 capacity, 3 conflict
  task automatic acc(input int line, input bit vld, input bit hit, input bit half,
                     input bit wr, input int cls, input string tag);
    exp_t it;
    @(negedge clk);
    acc_valid = vld;
    acc_line  = LW'(line);
    acc_hit   = hit;
    acc_half  = half;
    acc_write = wr;
    if (cls != 0) begin
      e[cls-1]++;
      if (wr) e[4]++;
      else e[3]++;
    end
    it.due = cyc + 1;
    it.e   = e;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    @(negedge clk);
    acc_valid = 1'b0;
    while (q.size() > 0) @(negedge clk);
  endtask

  function automatic longint sat(input int v);
    return (v > 7) ? 7 : v;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) e[i] = 0;
    // R1: first cycle after release
    chk(acc_ready == 1'b0, "R1", "ready right after reset", acc_ready, 0);
    @(negedge clk);
    chk(acc_ready == 1'b1, "R1", "ready one cycle later", acc_ready, 1);
    // R10
    chk(c_comp == 0 && c_cap == 0 && c_conf == 0, "R10", "class counters zero",
        c_comp + c_cap + c_conf, 0);
    chk(c_rd == 0 && c_wr == 0, "R10", "rd/wr counters zero", c_rd + c_wr, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R2 / R7: fresh lines 0..7, writes on 1 and 3
    for (int i = 0; i < 8; i++) acc(i, 1, 0, 0, (i == 1 || i == 3), 1, "R2");
    // R4: line 0 still in window
    acc(0, 1, 0, 0, 0, 3, "R4");
    // fresh lines 8..15 push 0..7 out
    for (int i = 8; i < 16; i++) acc(i, 1, 0, 0, 0, 1, "R2");
    // R3: line 2 seen but out of window
    acc(2, 1, 0, 0, 1, 2, "R3");
    // R8: window now 2,15..9 ; hit on 9 refreshes it, 10 becomes LRU
    acc(9, 1, 1, 0, 0, 0, "R6");
    acc(16, 1, 0, 0, 0, 1, "R8");
    acc(9, 1, 0, 0, 0, 3, "R8");
    acc(10, 1, 0, 0, 0, 2, "R8");
    // R5: half-miss leaves line 100 unseen
    acc(100, 1, 0, 1, 0, 0, "R5");
    acc(100, 1, 0, 0, 0, 1, "R5");
    // R6: hit marks line 101 and makes it recent
    acc(101, 1, 1, 0, 0, 0, "R6");
    acc(101, 1, 0, 0, 1, 3, "R6");
    // R1: idle cycle on line 102 has no effect
    acc(102, 0, 0, 0, 0, 0, "R1");
    acc(102, 1, 0, 0, 0, 1, "R1");
    drain();
    // R9: 3-bit instance saturates
    chk(s_comp == SW'(sat(e[0])), "R9", "sat comp_cnt", s_comp, sat(e[0]));
    chk(s_cap  == SW'(sat(e[1])), "R9", "sat cap_cnt",  s_cap,  sat(e[1]));
    chk(s_conf == SW'(sat(e[2])), "R9", "sat conf_cnt", s_conf, sat(e[2]));
    chk(s_rd   == SW'(sat(e[3])), "R9", "sat rd_miss_cnt", s_rd, sat(e[3]));
    chk(s_wr   == SW'(sat(e[4])), "R9", "sat wr_miss_cnt", s_wr, sat(e[4]));
    // R10: after reset, an old line is compulsory again
    do_reset();
    acc(0, 1, 0, 0, 0, 1, "R10");
    acc(0, 1, 0, 0, 1, 3, "R10");
    drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule